// File: doc/BRIEF.md
# Sliding-Window Jitter Measurement Sequencer

This block sequences a serial-data eye and jitter analyzer over a compliance record held in a buffer. Each buffered unit interval (UI) is presented to the analyzer in turn, and a UI-valid strobe marks the cycles that carry one. After a start pulse, the sequencer walks a clock-recovery window of fixed length across the record. It raises a recover-enable for every UI of the window and gives the buffer address as window start plus offset. Over the centred slice of the window it also raises an accumulate-enable, so that only that slice is folded into the eye and jitter accumulator.

When the last offset of a window is consumed, the sequencer pulses window-done and bumps the measurement count. It then moves the window start forward by a fixed step and walks the record again from the new start. Windows overlap heavily, so one record yields many composite measurements. A window is launched only when it ends strictly before the last UI of the record. Once no further window fits, all-done rises and stays high until the next start. With the default sizes (3500-UI window, 250-UI slice, 100-UI step), a 25,000-UI record gives 215 measurements.

Top module: `jit_win_seq`

## Requirements
- R1: After synchronous reset, recover-enable, accumulate-enable, window-done and all-done are low and the measurement count is 0.
- R2: A start pulse seen while no run is active latches the record length, clears the count and all-done, and begins a window at UI index 0 when that window fits.
- R3: While a run is active, recover-enable equals ui_valid, and ui_index gives window start plus the current offset. The offset advances by one only on cycles with ui_valid high; on other cycles ui_index holds.
- R4: Accumulate-enable is high only on recover-enable cycles whose offset lies in the centred slice, which starts at (WIN_LEN-SLICE_LEN)/2 and is SLICE_LEN UI long. With the defaults this is offsets 1625 to 1874.
- R5: Window-done pulses for exactly the one recover-enable cycle at offset WIN_LEN-1 (3499 by default). The next UI then uses offset 0.
- R6: After window-done, the next window starts STEP UI (100 by default) beyond the previous window start.
- R7: A window at start s is launched only if s + WIN_LEN < record length. A start pulse for a record too short for any window gives all-done on the next cycle, with a count of 0. The defaults give 215 windows for a 25,000-UI record.
- R8: All-done rises when no further window fits and stays high until the next accepted start. While it is high, ui_valid produces no recover-enable and no change in the count.
- R9: A start pulse that arrives during an active run is ignored: the window walk, the latched length and the count carry on unchanged.
- R10: The measurement count (CNT_W = 8 bits) increases by one at each window-done, so at the end of a run it equals the number of windows launched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run over the buffered record |
| ui_valid | input | 1 | One buffered UI is presented this cycle |
| rec_len | input | IDX_W | Record length in UI, latched on an accepted start |
| rec_en | output | 1 | Recover-enable: current UI belongs to the active window |
| acc_en | output | 1 | Accumulate-enable: current UI lies in the centred slice |
| win_done | output | 1 | One-cycle strobe at the last UI of a window |
| ui_index | output | IDX_W | Buffer address of the current UI (window start plus offset) |
| meas_count | output | CNT_W | Number of completed windows in this run |
| all_done | output | 1 | Run complete; held until the next accepted start |

## Verification
On every cycle, the assertions check the following: accumulate-enable only occurs under recover-enable, and the offset either steps by one or wraps at the window end. The address holds when no UI is presented. Each window advances its start by the fixed step, and every active window fits inside the latched length. The count steps exactly once per window-done, and all-done is sticky. Only the bench scenarios can show the absolute slice position, the exact number of windows for a given record length, the zero-window case, and that a mid-run start leaves the walk untouched. The bench gets these from its own model of the window arithmetic, using reduced sizes.

// File: rtl/jit_win_seq_pkg.sv
package jit_win_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;

    // true when offset lies in [lo, lo+len)
    function automatic logic slice_hit(input int unsigned off,
                                       input int unsigned lo,
                                       input int unsigned len);
        return (off >= lo) && (off < lo + len);
    endfunction

    // a window at start s fits when it ends strictly before the record's last UI
    function automatic logic window_fits(input int unsigned s,
                                         input int unsigned win,
                                         input int unsigned len);
        return (s + win) < len;
    endfunction

endpackage

// File: rtl/seq_offset_ctr.sv
module seq_offset_ctr
    import jit_win_seq_pkg::*;
#(
    parameter int unsigned WIN_LEN   = 3500,
    parameter int unsigned SLICE_LEN = 250,
    localparam int unsigned OFF_W    = $clog2(WIN_LEN),
    localparam int unsigned SLICE_LO = (WIN_LEN - SLICE_LEN) / 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             step_en,
    output logic [OFF_W-1:0] offset,
    output logic             win_last,
    output logic             in_slice
);

    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(WIN_LEN - 1);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            offset <= '0;
        end else if (step_en) begin
            offset <= win_last ? '0 : offset + 1'b1;
        end
    end

    always_comb begin
        win_last = (offset == LAST_OFF);
        in_slice = slice_hit(32'(offset), SLICE_LO, SLICE_LEN);
    end

    AST_OFFSET_WRAP: assert property (@(posedge clk) disable iff (rst)
        (step_en && win_last && !clr) |=> (offset == '0)); // R5

    AST_OFFSET_STEP: assert property (@(posedge clk) disable iff (rst)
        (step_en && !win_last && !clr) |=> (offset == $past(offset) + 1'b1)); // R3

endmodule

// File: rtl/seq_window_ctl.sv
module seq_window_ctl
    import jit_win_seq_pkg::*;
#(
    parameter int unsigned WIN_LEN = 3500,
    parameter int unsigned STEP    = 100,
    parameter int unsigned IDX_W   = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_ok,
    input  logic [IDX_W-1:0] rec_len,
    input  logic             win_done,
    output seq_state_e       state,
    output logic [IDX_W-1:0] win_start
);

    logic [IDX_W-1:0] rec_len_q;
    int unsigned      next_start;
    logic             next_fits;
    logic             first_fits;

    always_comb begin
        next_start = 32'(win_start) + STEP;
        next_fits  = window_fits(next_start, WIN_LEN, 32'(rec_len_q));
        first_fits = window_fits(0, WIN_LEN, 32'(rec_len));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            win_start <= '0;
            rec_len_q <= '0;
        end else if (start_ok) begin
            rec_len_q <= rec_len;
            win_start <= '0;
            state     <= first_fits ? ST_RUN : ST_DONE;
        end else if (win_done) begin
            if (next_fits) begin
                win_start <= next_start[IDX_W-1:0];
            end else begin
                state <= ST_DONE;
            end
        end
    end

    AST_WIN_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (win_done && !start_ok && state == ST_RUN) |=>
            (state == ST_DONE || 32'(win_start) == 32'($past(win_start)) + STEP)); // R6

    AST_WIN_FITS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN) |-> (32'(win_start) + WIN_LEN < 32'(rec_len_q))); // R7

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DONE && !start_ok) |=> (state == ST_DONE)); // R8

    AST_LEN_KEPT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && !start_ok) |=> $stable(rec_len_q)); // R9

endmodule

// File: rtl/seq_meas_ctr.sv
module seq_meas_ctr #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr) |=> (count == CNT_W'($past(count) + 1'b1))); // R10

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!inc && !clr) |=> $stable(count)); // R10

endmodule

// File: rtl/jit_win_seq.sv
module jit_win_seq
    import jit_win_seq_pkg::*;
#(
    parameter int unsigned WIN_LEN   = 3500,
    parameter int unsigned SLICE_LEN = 250,
    parameter int unsigned STEP      = 100,
    parameter int unsigned IDX_W     = 16,
    parameter int unsigned CNT_W     = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             ui_valid,
    input  logic [IDX_W-1:0] rec_len,
    output logic             rec_en,
    output logic             acc_en,
    output logic             win_done,
    output logic [IDX_W-1:0] ui_index,
    output logic [CNT_W-1:0] meas_count,
    output logic             all_done
);

    localparam int unsigned OFF_W = $clog2(WIN_LEN);

    seq_state_e       state;
    logic [IDX_W-1:0] win_start;
    logic [OFF_W-1:0] offset;
    logic             win_last;
    logic             in_slice;
    logic             start_ok;

    always_comb begin
        start_ok = start && (state != ST_RUN);
        rec_en   = (state == ST_RUN) && ui_valid;
        acc_en   = rec_en && in_slice;
        win_done = rec_en && win_last;
        ui_index = win_start + IDX_W'(offset);
        all_done = (state == ST_DONE);
    end

    seq_window_ctl #(
        .WIN_LEN (WIN_LEN),
        .STEP    (STEP),
        .IDX_W   (IDX_W)
    ) win_ctl_i (
        .clk       (clk),
        .rst       (rst),
        .start_ok  (start_ok),
        .rec_len   (rec_len),
        .win_done  (win_done),
        .state     (state),
        .win_start (win_start)
    );

    seq_offset_ctr #(
        .WIN_LEN   (WIN_LEN),
        .SLICE_LEN (SLICE_LEN)
    ) off_ctr_i (
        .clk      (clk),
        .rst      (rst),
        .clr      (start_ok),
        .step_en  (rec_en),
        .offset   (offset),
        .win_last (win_last),
        .in_slice (in_slice)
    );

    seq_meas_ctr #(
        .CNT_W (CNT_W)
    ) meas_ctr_i (
        .clk   (clk),
        .rst   (rst),
        .clr   (start_ok),
        .inc   (win_done),
        .count (meas_count)
    );

    AST_ACC_UNDER_REC: assert property (@(posedge clk) disable iff (rst)
        acc_en |-> rec_en); // R4

    AST_INDEX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!rec_en && !start) |=> $stable(ui_index)); // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (win_done && !start) |=> !win_done); // R5

    AST_IDLE_WHEN_DONE: assert property (@(posedge clk) disable iff (rst)
        all_done |-> !rec_en); // R8

endmodule

// File: tb/jit_win_seq_tb_top.sv
`timescale 1ns/1ps
module jit_win_seq_tb_top;

    localparam int unsigned WIN   = 20;
    localparam int unsigned SLEN  = 4;
    localparam int unsigned STEPV = 3;
    localparam int unsigned IW    = 16;
    localparam int unsigned CW    = 8;
    localparam int unsigned SLO   = (WIN - SLEN) / 2;   // 8: slice is offsets 8..11
    localparam int NVEC = 7;
    // columns: record length, expected windows, flags (bit0 = idle gaps, bit1 = start mid-run)
    localparam int unsigned VEC [NVEC][3] = '{
        '{21, 1, 0},
        '{30, 4, 1},
        '{24, 2, 2},
        '{20, 0, 0},
        '{40, 7, 3},
        '{5,  0, 0},
        '{23, 1, 0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          ui_valid = 1'b0;
    logic [IW-1:0] rec_len = '0;
    logic          rec_en, acc_en, win_done, all_done;
    logic [IW-1:0] ui_index;
    logic [CW-1:0] meas_count;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    jit_win_seq #(
        .WIN_LEN (WIN), .SLICE_LEN (SLEN), .STEP (STEPV), .IDX_W (IW), .CNT_W (CW)
    ) dut_i (
        .clk (clk), .rst (rst), .start (start), .ui_valid (ui_valid),
        .rec_len (rec_len), .rec_en (rec_en), .acc_en (acc_en),
        .win_done (win_done), .ui_index (ui_index),
        .meas_count (meas_count), .all_done (all_done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        check(act == exp, tag, act, exp);
    endtask

    task automatic run_record(input int unsigned len, input int unsigned exp_win,
                              input int unsigned flags);
        @(negedge clk);
        rec_len = IW'(len);
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        #1;
        chk("R2 count cleared by start", int'(meas_count), 0);
        if (exp_win == 0) begin
            chk("R7 too-short record ends at once", int'(all_done), 1);
            ui_valid = 1'b1;
            #1;
            chk("R8 no recover when done", int'(rec_en), 0);
            ui_valid = 1'b0;
        end else begin
            chk("R2 all_done cleared by start", int'(all_done), 0);
            chk("R2 first window at index 0", int'(ui_index), 0);
        end
        for (int w = 0; w < int'(exp_win); w++) begin
            for (int o = 0; o < int'(WIN); o++) begin
                if (flags[0] && (o % 5 == 2)) begin
                    @(negedge clk);
                    ui_valid = 1'b0;
                    #1;
                    chk("R3 rec_en low without ui_valid", int'(rec_en), 0);
                    chk("R3 index holds without ui_valid", int'(ui_index), w * STEPV + o);
                    chk("R4 acc_en low without ui_valid", int'(acc_en), 0);
                end
                @(negedge clk);
                ui_valid = 1'b1;
                if (flags[1] && w == 0 && o == 5) begin
                    start   = 1'b1;
                    rec_len = IW'(100);
                end else begin
                    start   = 1'b0;
                    rec_len = IW'(len);
                end
                #1;
                chk("R3 rec_en follows ui_valid", int'(rec_en), 1);
                chk("R3 ui_index is start plus offset", int'(ui_index), w * STEPV + o);
                chk("R4 slice accumulate", int'(acc_en),
                    (o >= int'(SLO) && o < int'(SLO + SLEN)) ? 1 : 0);
                chk("R5 window-done strobe", int'(win_done), (o == int'(WIN) - 1) ? 1 : 0);
                chk("R10 running count", int'(meas_count), w);
                if (o == 0 && w > 0)
                    chk("R6 window advanced by step", int'(ui_index), w * STEPV);
            end
        end
        @(negedge clk);
        ui_valid = 1'b0;
        start    = 1'b0;
        #1;
        chk("R7 window count for record", int'(meas_count), int'(exp_win));
        chk("R8 all_done after last window", int'(all_done), 1);
        if (flags[1])
            chk("R9 mid-run start ignored", int'(meas_count), int'(exp_win));
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            ui_valid = 1'b1;
            #1;
            chk("R8 all_done held", int'(all_done), 1);
            chk("R8 ui_valid ignored when done", int'(rec_en), 0);
        end
        @(negedge clk);
        ui_valid = 1'b0;
        #1;
        chk("R8 count unchanged when done", int'(meas_count), int'(exp_win));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset rec_en", int'(rec_en), 0);
        chk("R1 reset acc_en", int'(acc_en), 0);
        chk("R1 reset win_done", int'(win_done), 0);
        chk("R1 reset all_done", int'(all_done), 0);
        chk("R1 reset count", int'(meas_count), 0);
        ui_valid = 1'b1;
        #1;
        chk("R1 idle ignores ui_valid", int'(rec_en), 0);
        ui_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        for (int v = 0; v < NVEC; v++)
            run_record(VEC[v][0], VEC[v][1], VEC[v][2]);
        // reset in the middle of a run
        @(negedge clk);
        rec_len = IW'(40);
        start   = 1'b1;
        @(negedge clk);
        start    = 1'b0;
        ui_valid = 1'b1;
        repeat (25) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        ui_valid = 1'b0;
        #1;
        chk("R1 reset mid-run count", int'(meas_count), 0);
        chk("R1 reset mid-run rec_en", int'(rec_en), 0);
        chk("R1 reset mid-run all_done", int'(all_done), 0);
        rst = 1'b0;
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(200_000 * 10);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule